// File: doc/BRIEF.md
# Frame Pointer State Tracker

This block follows the payload pointer carried in the two pointer bytes of each received frame. A framer upstream locates the two bytes, and the 1+1 protection selector has already chosen the line they came from. Once per frame the framer hands the byte pair to this block. The block sorts each pair into one of several kinds: a plain pointer, a pointer with the new-data flag set, a one-step increment or decrement, an all-ones alarm word, a concatenation indication, or an invalid word. It then runs a three-state machine with the states normal, alarm (path AIS) and loss of pointer.

The control side sees the current state, the active pointer value, and one-cycle event pulses. There is a pulse for an increment, for a decrement, for a pointer jump (a new value accepted) and for any change of state. When the concatenation-expected input is high, the block expects concatenation indications in place of real pointers. In that mode it never adjusts the pointer.

The frame input is a valid/ready stream of one byte pair per beat. `in_ready` is always high, so the block applies no back-pressure and takes a pair on every cycle in which `in_valid` is high. A beat with `in_valid` low is not a frame. All outputs are registered and reflect a frame on the clock edge after it is accepted.

Top module: `pointer_interp`

## Requirements
- R1: After reset the state is loss of pointer (code 2), the pointer value is 0, all event pulses are low, and `in_ready` stays high at all times.
- R2: The 16-bit word is {h1,h2}. Bits 15:12 are the new-data flag: 0110 is normal and 1001 is set. Bits 9:0 are the pointer. A pointer is valid only from 0 to 782, and in the normal state the reported pointer never exceeds 782.
- R3: In concatenation-off mode, the same valid pointer with a normal flag on three consecutive frames is accepted. The state becomes normal (code 0), the value is loaded and `jump_evt` pulses.
- R4: In concatenation-off mode, a valid pointer with the flag set (1001) is accepted at once from any state, with `jump_evt`.
- R5: Three consecutive all-ones words (0xFFFF) move the block to the alarm state (code 1). Two do not.
- R6: Nine consecutive invalid frames move the block to loss of pointer, and eight do not. A frame counts as invalid if it has a bad flag, an out-of-range pointer, or a mismatched pointer that has not yet been accepted, such as two values that alternate.
- R7: In the normal state, a word with a normal flag is an increment when at least three of bits 9,7,5,3,1 differ from the active pointer and fewer than three of bits 8,6,4,2,0 do. `inc_evt` pulses and the value becomes value+1, with 782 wrapping to 0.
- R8: In the same way, at least three differing bits among 8,6,4,2,0 and fewer than three among 9,7,5,3,1 make a decrement. `dec_evt` pulses and the value becomes value-1, with 0 wrapping to 782.
- R9: With `concat_exp` high, a concatenation indication is flag 1001 with bits 9:0 all ones. Nine consecutive other non-alarm words give loss of pointer. Three consecutive indications return the block to normal with the value unchanged. No increment or decrement is ever made in this mode.
- R10: `state_chg` pulses for exactly the cycle in which the reported state differs from the previous cycle. Outputs update one clock after the accepted frame.
- R11: Beats with `in_valid` low change no output and no counter.
- R12: In the normal state, a frame that repeats the active pointer clears the invalid-frame count, so eight invalid frames, one good frame and eight more invalid frames keep the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte pair present |
| in_ready | output | 1 | Always high; no back-pressure |
| in_h1 | input | 8 | First pointer byte |
| in_h2 | input | 8 | Second pointer byte |
| concat_exp | input | 1 | Expect concatenation indications |
| ptr_state | output | 2 | 0 normal, 1 alarm, 2 loss of pointer |
| ptr_value | output | 10 | Active pointer |
| inc_evt | output | 1 | Increment pulse |
| dec_evt | output | 1 | Decrement pulse |
| jump_evt | output | 1 | New pointer accepted pulse |
| state_chg | output | 1 | State changed pulse |

## Verification
The hardest state to reach from the ports is loss of pointer caused by pointers that are each in range but never agree. Each such frame restarts the three-frame acceptance run while the invalid count keeps growing. The stimulus alternates two in-range values chosen so that neither looks like an increment or decrement against the active pointer. It then checks that the eighth frame still leaves the state normal and that the ninth declares the loss. Each adjustment pattern is built by XOR-ing the active pointer with the odd-bit or even-bit mask, including at the 782 and 0 wrap points.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [1:0] {ST_NORM = 2'd0, ST_AIS = 2'd1, ST_LOP = 2'd2} pstate_e;
  typedef enum logic [2:0] {
    FK_AIS, FK_INC, FK_DEC, FK_NDF, FK_NORMP, FK_CONC, FK_INV
  } fkind_e;
  localparam int WORD_W = 16;
  localparam logic [3:0] FLAG_NORM = 4'b0110;
  localparam logic [3:0] FLAG_SET  = 4'b1001;
endpackage

// File: rtl/ptr_classify.sv
module ptr_classify import pi_pkg::*; #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 782
) (
  input  logic [WORD_W-1:0] word,
  input  logic [PTR_W-1:0]  act,
  input  logic              in_norm,
  input  logic              concat_exp,
  output fkind_e            kind,
  output logic [PTR_W-1:0]  ptr
);
  localparam int HALF_N = PTR_W / 2;
  localparam int MAJ    = HALF_N / 2;

  logic [3:0]       flag;
  logic [PTR_W-1:0] diff;
  logic [HALF_N-1:0] ibit, dbit;
  logic is_ais, is_conc, in_range, maj_i, maj_d, f_norm, f_set;

  assign flag     = word[WORD_W-1:WORD_W-4];
  assign ptr      = word[PTR_W-1:0];
  assign diff     = ptr ^ act;
  assign is_ais   = &word;
  assign f_norm   = (flag == FLAG_NORM);
  assign f_set    = (flag == FLAG_SET);
  assign is_conc  = f_set && (&ptr);
  assign in_range = (ptr <= PTR_W'(PTR_MAX));

  for (genvar g = 0; g < HALF_N; g++) begin : g_split
    assign ibit[g] = diff[2*g+1];
    assign dbit[g] = diff[2*g];
  end

  assign maj_i = ($countones(ibit) > MAJ);
  assign maj_d = ($countones(dbit) > MAJ);

  always_comb begin
    if (is_ais)                                      kind = FK_AIS;
    else if (concat_exp)                             kind = is_conc ? FK_CONC : FK_INV;
    else if (in_norm && f_norm && maj_i && !maj_d)   kind = FK_INC;
    else if (in_norm && f_norm && maj_d && !maj_i)   kind = FK_DEC;
    else if (f_set && in_range)                      kind = FK_NDF;
    else if (f_norm && in_range)                     kind = FK_NORMP;
    else                                             kind = FK_INV;
  end
endmodule

// File: rtl/ptr_fsm.sv
module ptr_fsm import pi_pkg::*; #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 782,
  parameter int INV_N   = 9,
  parameter int AIS_N   = 3,
  parameter int ACC_N   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  fkind_e           kind,
  input  logic [PTR_W-1:0] ptr,
  output pstate_e          st,
  output logic [PTR_W-1:0] act,
  output logic             inc_o,
  output logic             dec_o,
  output logic             jmp_o,
  output logic             chg_o
);
  localparam int IW = $clog2(INV_N + 1);
  localparam int SW = $clog2(AIS_N + 1);
  localparam int CW = $clog2(ACC_N + 1);

  logic [IW-1:0] inv_c, n_inv;
  logic [SW-1:0] ais_c, n_ais;
  logic [CW-1:0] acc_c, n_acc;
  logic [PTR_W-1:0] cand, n_cand, n_act;
  pstate_e n_st;
  logic n_inc, n_dec, n_jmp, bump;

  always_comb begin
    n_st = st; n_act = act; n_inv = inv_c; n_ais = ais_c;
    n_acc = acc_c; n_cand = cand;
    n_inc = 1'b0; n_dec = 1'b0; n_jmp = 1'b0; bump = 1'b0;
    if (vld) begin
      n_ais = '0;
      unique case (kind)
        FK_AIS: begin
          if (ais_c < SW'(AIS_N)) n_ais = ais_c + SW'(1);
          n_inv = '0; n_acc = '0;
          if (ais_c >= SW'(AIS_N - 1)) n_st = ST_AIS;
        end
        FK_INC: begin
          n_act = (act == PTR_W'(PTR_MAX)) ? '0 : act + PTR_W'(1);
          n_inc = 1'b1; n_inv = '0; n_acc = '0;
        end
        FK_DEC: begin
          n_act = (act == '0) ? PTR_W'(PTR_MAX) : act - PTR_W'(1);
          n_dec = 1'b1; n_inv = '0; n_acc = '0;
        end
        FK_NDF: begin
          n_act = ptr; n_st = ST_NORM; n_jmp = 1'b1;
          n_inv = '0; n_acc = '0;
        end
        FK_NORMP: begin
          if (st == ST_NORM && ptr == act) begin
            n_inv = '0; n_acc = '0;
          end else begin
            if (acc_c != '0 && ptr == cand) n_acc = acc_c + CW'(1);
            else begin n_acc = CW'(1); n_cand = ptr; end
            if (n_acc >= CW'(ACC_N)) begin
              n_act = ptr; n_st = ST_NORM; n_jmp = 1'b1;
              n_inv = '0; n_acc = '0;
            end else bump = 1'b1;
          end
        end
        FK_CONC: begin
          if (st == ST_NORM) begin
            n_inv = '0; n_acc = '0;
          end else if (acc_c >= CW'(ACC_N - 1)) begin
            n_st = ST_NORM; n_inv = '0; n_acc = '0;
          end else n_acc = acc_c + CW'(1);
        end
        default: begin
          n_acc = '0; bump = 1'b1;
        end
      endcase
      if (bump) begin
        if (inv_c >= IW'(INV_N - 1)) begin
          n_inv = IW'(INV_N - 1);
          if (st != ST_LOP) begin n_st = ST_LOP; n_acc = '0; end
        end else n_inv = inv_c + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_LOP; act <= '0; inv_c <= '0; ais_c <= '0; acc_c <= '0;
      cand <= '0; inc_o <= 1'b0; dec_o <= 1'b0; jmp_o <= 1'b0; chg_o <= 1'b0;
    end else begin
      st <= n_st; act <= n_act; inv_c <= n_inv; ais_c <= n_ais;
      acc_c <= n_acc; cand <= n_cand;
      inc_o <= n_inc; dec_o <= n_dec; jmp_o <= n_jmp;
      chg_o <= (n_st != st);
    end
  end
endmodule

// File: rtl/pointer_interp.sv
module pointer_interp import pi_pkg::*; #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 782,
  parameter int INV_N   = 9,
  parameter int AIS_N   = 3,
  parameter int ACC_N   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_h1,
  input  logic [7:0]       in_h2,
  input  logic             concat_exp,
  output logic [1:0]       ptr_state,
  output logic [PTR_W-1:0] ptr_value,
  output logic             inc_evt,
  output logic             dec_evt,
  output logic             jump_evt,
  output logic             state_chg
);
  fkind_e           kind;
  logic [PTR_W-1:0] rx_ptr;
  pstate_e          st;

  assign in_ready  = 1'b1;
  assign ptr_state = st;

  ptr_classify #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX)) u_cls (
    .word({in_h1, in_h2}), .act(ptr_value), .in_norm(st == ST_NORM),
    .concat_exp(concat_exp), .kind(kind), .ptr(rx_ptr)
  );

  ptr_fsm #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .INV_N(INV_N),
            .AIS_N(AIS_N), .ACC_N(ACC_N)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vld(in_valid && in_ready), .kind(kind),
    .ptr(rx_ptr), .st(st), .act(ptr_value), .inc_o(inc_evt),
    .dec_o(dec_evt), .jmp_o(jump_evt), .chg_o(state_chg)
  );
endmodule

// File: rtl/pi_checker.sv
module pi_checker #(
  parameter int PTR_W   = 10,
  parameter int PTR_MAX = 782
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             concat_exp,
  input logic [1:0]       ptr_state,
  input logic [PTR_W-1:0] ptr_value,
  input logic             inc_evt,
  input logic             dec_evt,
  input logic             jump_evt,
  input logic             state_chg
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R1
  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n) ptr_state != 2'd3); // R10
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_state == 2'd0 |-> ptr_value <= PTR_W'(PTR_MAX)); // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_evt, dec_evt, jump_evt})); // R7
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> ptr_value == (($past(ptr_value) == PTR_W'(PTR_MAX)) ? '0 : $past(ptr_value) + PTR_W'(1))); // R7
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |-> ptr_value == (($past(ptr_value) == '0) ? PTR_W'(PTR_MAX) : $past(ptr_value) - PTR_W'(1))); // R8
  AST_CHG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg == (ptr_state != $past(ptr_state))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ptr_state) && $stable(ptr_value) && !inc_evt && !dec_evt); // R11
  AST_CONC_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    concat_exp |=> !inc_evt && !dec_evt); // R9
endmodule

bind pointer_interp pi_checker #(.PTR_W(PTR_W), .PTR_MAX(PTR_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .concat_exp(concat_exp), .ptr_state(ptr_state), .ptr_value(ptr_value),
  .inc_evt(inc_evt), .dec_evt(dec_evt), .jump_evt(jump_evt), .state_chg(state_chg)
);

// File: tb/sim_pointer_interp.sv
module sim_pointer_interp;
  typedef struct packed {
    logic [7:0]  rep;
    logic        v;
    logic        c;
    logic [15:0] w;
    logic [1:0]  st;
    logic [9:0]  p;
    logic        inc;
    logic        dec;
    logic        jmp;
    logic        chg;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{8'd3, 1'b1, 1'b0, 16'h6064, 2'd0, 10'd100, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3},  // R3
    '{8'd1, 1'b1, 1'b0, 16'h6064, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{8'd1, 1'b1, 1'b0, 16'h62CE, 2'd0, 10'd101, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
    '{8'd1, 1'b1, 1'b0, 16'h6130, 2'd0, 10'd100, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8
    '{8'd4, 1'b0, 1'b0, 16'hFFFF, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11
    '{8'd8, 1'b1, 1'b0, 16'h0064, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6
    '{8'd1, 1'b1, 1'b0, 16'h6064, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12}, // R12
    '{8'd8, 1'b1, 1'b0, 16'h0064, 2'd0, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12}, // R12
    '{8'd1, 1'b1, 1'b0, 16'h0064, 2'd2, 10'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6
    '{8'd2, 1'b1, 1'b0, 16'hFFFF, 2'd2, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5
    '{8'd1, 1'b1, 1'b0, 16'hFFFF, 2'd1, 10'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5
    '{8'd1, 1'b1, 1'b0, 16'h9005, 2'd0, 10'd5,   1'b0, 1'b0, 1'b1, 1'b1, 8'd4},  // R4
    '{8'd1, 1'b1, 1'b0, 16'h930E, 2'd0, 10'd782, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4},  // R4
    '{8'd1, 1'b1, 1'b0, 16'h61A4, 2'd0, 10'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 wrap
    '{8'd1, 1'b1, 1'b0, 16'h6155, 2'd0, 10'd782, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 wrap
    '{8'd1, 1'b1, 1'b0, 16'h630C, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 alternation
    '{8'd1, 1'b1, 1'b0, 16'h630A, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630C, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630A, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630C, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630A, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630C, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630A, 2'd0, 10'd782, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{8'd1, 1'b1, 1'b0, 16'h630C, 2'd2, 10'd782, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6},
    '{8'd3, 1'b1, 1'b0, 16'h630C, 2'd0, 10'd780, 1'b0, 1'b0, 1'b1, 1'b1, 8'd3},  // R3 from loss
    '{8'd8, 1'b1, 1'b1, 16'h6064, 2'd0, 10'd780, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},  // R9
    '{8'd1, 1'b1, 1'b1, 16'h9FFF, 2'd0, 10'd780, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},
    '{8'd9, 1'b1, 1'b1, 16'h6064, 2'd2, 10'd780, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9},
    '{8'd2, 1'b1, 1'b1, 16'h9FFF, 2'd2, 10'd780, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},
    '{8'd1, 1'b1, 1'b1, 16'h9FFF, 2'd0, 10'd780, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9},
    '{8'd1, 1'b1, 1'b1, 16'h61A6, 2'd0, 10'd780, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9}   // R9 no inc
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, concat_exp = 1'b0;
  logic [7:0] in_h1 = 8'h00, in_h2 = 8'h00;
  logic in_ready, inc_evt, dec_evt, jump_evt, state_chg;
  logic [1:0] ptr_state;
  logic [9:0] ptr_value;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pointer_interp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_h1(in_h1), .in_h2(in_h2), .concat_exp(concat_exp),
    .ptr_state(ptr_state), .ptr_value(ptr_value), .inc_evt(inc_evt),
    .dec_evt(dec_evt), .jump_evt(jump_evt), .state_chg(state_chg)
  );

  task automatic check(input logic [7:0] req, input logic [1:0] st, input logic [9:0] p,
                       input logic [3:0] ev, input logic rdy);
    logic [3:0] got;
    got = {inc_evt, dec_evt, jump_evt, state_chg};
    n_chk++;
    if (ptr_state !== st || ptr_value !== p || got !== ev || in_ready !== rdy) begin
      n_fail++;
      $display("FAIL R%0d: state=%0d ptr=%0d ev=%b rdy=%b, expected state=%0d ptr=%0d ev=%b rdy=%b",
               req, ptr_state, ptr_value, got, in_ready, st, p, ev, rdy);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(8'd1, 2'd2, 10'd0, 4'b0000, 1'b1);  // R1 in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(8'd1, 2'd2, 10'd0, 4'b0000, 1'b1);  // R1 after release
    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < int'(TBL[i].rep); r++) begin
        in_valid = TBL[i].v; concat_exp = TBL[i].c;
        {in_h1, in_h2} = TBL[i].w;
        @(negedge clk);
      end
      check(TBL[i].req, TBL[i].st, TBL[i].p,
            {TBL[i].inc, TBL[i].dec, TBL[i].jmp, TBL[i].chg}, 1'b1);
    end
    in_valid = 1'b0; concat_exp = 1'b0;
    @(negedge clk);
    check(8'd10, 2'd0, 10'd780, 4'b0000, 1'b1);  // R10 pulses last one cycle
    // R5: two alarm words then a good one do not give alarm
    in_valid = 1'b1; {in_h1, in_h2} = 16'hFFFF;
    repeat (2) @(negedge clk);
    {in_h1, in_h2} = 16'h630C;
    @(negedge clk);
    check(8'd5, 2'd0, 10'd780, 4'b0000, 1'b1);
    in_valid = 1'b0;
    // R1: reset in mid-run returns to loss of pointer, value 0
    rst_n = 1'b0;
    @(negedge clk);
    check(8'd1, 2'd2, 10'd0, 4'b0000, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: out-of-range pointer with normal flag is never accepted
    in_valid = 1'b1; {in_h1, in_h2} = 16'h6320;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check(8'd2, 2'd2, 10'd0, 4'b0000, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule